// File: doc/BRIEF.md
# Trap Cause and Status Capture

This block keeps the trap state of a small RISC core. The core reports synchronous faults (fetch, load or store address errors, an undefined opcode, arithmetic overflow, a system call and a debug break) along with the program counter of the faulting instruction and a flag that marks whether it sat in a branch delay slot. Six hardware interrupt lines come in from outside the core.

Each cycle the block picks at most one trap by a fixed priority. A pending, unmasked interrupt qualifies only while interrupts are enabled and no trap is already being handled. When a trap is accepted the block pulses `take_exc` and records the trap state: a code number, the delay-slot flag and the restart address. It also raises the in-trap level bit, which holds off further interrupts until a return strobe clears it.

A simple write port lets software set the mask, mode and enable bits of the status word. The status, cause and restart-address registers are always visible on the outputs.

Top module: `trap_capture`

## Requirements
- R1: After a synchronous reset, `take_exc` is 0 and `status_q`, `cause_q` and `epc_q` all read 0.
- R2: `status_q` holds the interrupt mask in bits 15:8, the user-mode flag in bit 4, the in-trap level bit in bit 1 and the interrupt enable in bit 0. Every other bit reads 0.
- R3: `cause_q` holds the trap code in bits 6:2, the pending-interrupt field in bits 15:8 and the delay-slot flag in bit 31. Every other bit reads 0. The codes are: 0 interrupt, 4 fetch or load address error, 5 store address error, 8 system call, 9 break, 10 undefined opcode, 12 overflow.
- R4: Pending bits 15:10 copy `irq[5:0]` one clock after the lines change. Pending bits 9:8 always read 0. No write can change the pending bits.
- R5: An interrupt is accepted only when some pending bit and its mask bit are both 1, the enable bit is 1 and the in-trap level bit is 0. A line that is raised shows up on `take_exc` two clocks later.
- R6: Simultaneous requests resolve in this order, highest first: fetch address error, undefined opcode, overflow, load address error, store address error, system call, break, interrupt.
- R7: A core request sampled on a clock edge produces a one-cycle `take_exc` pulse after that edge. On the same edge the winning code is written and the in-trap level bit is set. Core requests are accepted whatever the level bit holds.
- R8: On an accepted trap, bit 31 of `cause_q` takes `in_delay`. `epc_q` takes `fault_pc`, or `fault_pc` minus 4 when `in_delay` is 1.
- R9: The `eret` strobe clears the in-trap level bit on the next edge. If a trap is accepted on the same edge, the level bit is set instead.
- R10: A status write updates only bits 15:8, 4, 1 and 0. Writing all ones therefore reads back as 0x0000FF13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_fetch_adr | input | 1 | Address error on instruction fetch |
| req_resv | input | 1 | Undefined opcode |
| req_ovf | input | 1 | Signed arithmetic overflow |
| req_load_adr | input | 1 | Address error on load |
| req_store_adr | input | 1 | Address error on store |
| req_sys | input | 1 | System call |
| req_brk | input | 1 | Debug break |
| irq | input | 6 | Hardware interrupt lines |
| fault_pc | input | 32 | Address of the faulting instruction |
| in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 32 | Status write data |
| eret | input | 1 | Return-from-trap strobe |
| take_exc | output | 1 | One-cycle pulse when a trap is accepted |
| status_q | output | 32 | Status register |
| cause_q | output | 32 | Cause register |
| epc_q | output | 32 | Restart address |

## Verification
All 127 non-empty combinations of the seven core requests are driven. Each one checks the recorded code, so a design with a swapped priority would report the wrong code for some overlap. An off-by-four restart address, or a wrong delay-slot flag, shows up in the same sweep. Every interrupt-line pattern is then crossed with several masks and all four enable and level combinations. This would catch interrupts taken during a handler, interrupts ignoring the mask, or interrupts from the always-zero pending bits. Writing all ones to status, and sending the return strobe together with a fault, check the write mask and the order in which updates to the level bit take effect.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NREQ = 7;
  localparam int CODEW = 5;

  // request index order is also priority order (0 = highest)
  localparam int RQ_FETCH = 0;
  localparam int RQ_RESV  = 1;
  localparam int RQ_OVF   = 2;
  localparam int RQ_LOAD  = 3;
  localparam int RQ_STORE = 4;
  localparam int RQ_SYS   = 5;
  localparam int RQ_BRK   = 6;

  typedef enum logic [CODEW-1:0] {
    TC_INT   = 5'd0,
    TC_ADR_L = 5'd4,
    TC_ADR_S = 5'd5,
    TC_SYS   = 5'd8,
    TC_BRK   = 5'd9,
    TC_RESV  = 5'd10,
    TC_OVF   = 5'd12
  } trap_code_e;

  function automatic trap_code_e code_of(input int idx);
    case (idx)
      RQ_FETCH: code_of = TC_ADR_L;
      RQ_RESV:  code_of = TC_RESV;
      RQ_OVF:   code_of = TC_OVF;
      RQ_LOAD:  code_of = TC_ADR_L;
      RQ_STORE: code_of = TC_ADR_S;
      RQ_SYS:   code_of = TC_SYS;
      default:  code_of = TC_BRK;
    endcase
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic [N-1:0]   req,
  input  logic           int_hit,
  output logic           valid,
  output trap_code_e     code
);
  always_comb begin
    valid = int_hit;
    code  = TC_INT;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        code  = code_of(i);
      end
    end
  end
endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int XLEN  = 32,
  parameter int MASKW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wdata,
  input  logic             eret,
  input  logic             take,
  output logic [MASKW-1:0] im_q,
  output logic             um_q,
  output logic             exl_q,
  output logic             ie_q
);
  localparam int IM_LO = 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      im_q  <= '0;
      um_q  <= 1'b0;
      exl_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        im_q  <= wdata[IM_LO +: MASKW];
        um_q  <= wdata[4];
        exl_q <= wdata[1];
        ie_q  <= wdata[0];
      end
      if (eret) exl_q <= 1'b0;
      if (take) exl_q <= 1'b1;
    end
  end

  p_take_sets_exl_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> exl_q);
  p_eret_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (eret && !take) |=> !exl_q);
endmodule

// File: rtl/trap_cause.sv
module trap_cause
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MASKW = 8,
  parameter int NHW   = 6,
  parameter int INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NHW-1:0]   irq,
  input  logic             take,
  input  trap_code_e       code_in,
  input  logic             in_delay,
  input  logic [XLEN-1:0]  fault_pc,
  output logic [MASKW-1:0] ip_q,
  output trap_code_e       code_q,
  output logic             bd_q,
  output logic [XLEN-1:0]  epc_q
);
  localparam int SWB = MASKW - NHW;

  logic [MASKW-1:0] ip_next;
  assign ip_next = MASKW'(irq) << SWB;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q   <= '0;
      code_q <= TC_INT;
      bd_q   <= 1'b0;
      epc_q  <= '0;
    end else begin
      ip_q <= ip_next;
      if (take) begin
        code_q <= code_in;
        bd_q   <= in_delay;
        epc_q  <= in_delay ? fault_pc - XLEN'(INSN_BYTES) : fault_pc;
      end
    end
  end

  p_ip_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ip_q[MASKW-1:SWB] == $past(irq));
  p_bd_capture_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> bd_q == $past(in_delay));
  p_epc_plain_r8: assert property (@(posedge clk) disable iff (rst)
    (take && !in_delay) |=> epc_q == $past(fault_pc));
endmodule

// File: rtl/trap_capture.sv
module trap_capture
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NHW  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_fetch_adr,
  input  logic            req_resv,
  input  logic            req_ovf,
  input  logic            req_load_adr,
  input  logic            req_store_adr,
  input  logic            req_sys,
  input  logic            req_brk,
  input  logic [NHW-1:0]  irq,
  input  logic [XLEN-1:0] fault_pc,
  input  logic            in_delay,
  input  logic            st_wr,
  input  logic [XLEN-1:0] st_wdata,
  input  logic            eret,
  output logic            take_exc,
  output logic [XLEN-1:0] status_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q
);
  localparam int MASKW = 8;
  localparam int ST_PAD = XLEN - 16;
  localparam int CA_PAD = XLEN - 17;

  logic [NREQ-1:0]  req;
  logic [MASKW-1:0] im, ip;
  logic             um, exl, ie, bd;
  logic             int_hit, take_d;
  trap_code_e       code_d, code;

  assign req[RQ_FETCH] = req_fetch_adr;
  assign req[RQ_RESV]  = req_resv;
  assign req[RQ_OVF]   = req_ovf;
  assign req[RQ_LOAD]  = req_load_adr;
  assign req[RQ_STORE] = req_store_adr;
  assign req[RQ_SYS]   = req_sys;
  assign req[RQ_BRK]   = req_brk;

  assign int_hit = (|(ip & im)) && ie && !exl;

  trap_arbiter #(.N(NREQ)) u_arb (
    .req(req), .int_hit(int_hit), .valid(take_d), .code(code_d)
  );

  trap_status #(.XLEN(XLEN), .MASKW(MASKW)) u_st (
    .clk(clk), .rst(rst), .wr_en(st_wr), .wdata(st_wdata), .eret(eret),
    .take(take_d), .im_q(im), .um_q(um), .exl_q(exl), .ie_q(ie)
  );

  trap_cause #(.XLEN(XLEN), .MASKW(MASKW), .NHW(NHW)) u_ca (
    .clk(clk), .rst(rst), .irq(irq), .take(take_d), .code_in(code_d),
    .in_delay(in_delay), .fault_pc(fault_pc), .ip_q(ip), .code_q(code),
    .bd_q(bd), .epc_q(epc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) take_exc <= 1'b0;
    else     take_exc <= take_d;
  end

  assign status_q = {{ST_PAD{1'b0}}, im, 3'b000, um, 2'b00, exl, ie};
  assign cause_q  = {bd, {CA_PAD{1'b0}}, ip, 1'b0, code, 2'b00};

  p_int_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (take_d && req == '0) |-> (ie && !exl));
  p_pulse_exl_r7: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> exl);
  p_fetch_wins_r6: assert property (@(posedge clk) disable iff (rst)
    req_fetch_adr |=> (take_exc && code == TC_ADR_L));
endmodule

// File: tb/sim_trap_capture.sv
`timescale 1ns/1ps
module sim_trap_capture;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic req_fetch_adr, req_resv, req_ovf, req_load_adr, req_store_adr, req_sys, req_brk;
  logic [5:0]  irq;
  logic [31:0] fault_pc, st_wdata, status_q, cause_q, epc_q;
  logic in_delay, st_wr, eret, take_exc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  trap_capture u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [6:0] v);
    {req_brk, req_sys, req_store_adr, req_load_adr, req_ovf, req_resv, req_fetch_adr} = v;
  endtask

  function automatic logic [4:0] exp_code(input logic [6:0] v);
    if (v[0]) return 5'd4;
    if (v[1]) return 5'd10;
    if (v[2]) return 5'd12;
    if (v[3]) return 5'd4;
    if (v[4]) return 5'd5;
    if (v[5]) return 5'd8;
    return 5'd9;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; set_req('0); irq = '0; fault_pc = '0; in_delay = 0;
    st_wr = 0; st_wdata = '0; eret = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 take", {31'b0, take_exc}, 32'h0);
    chk("R1 status", status_q, 32'h0);
    chk("R1 cause", cause_q, 32'h0);
    chk("R1 epc", epc_q, 32'h0);

    // R10 / R2: write mask
    st_wr = 1; st_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    st_wr = 0;
    chk("R10 all-ones write", status_q, 32'h0000_FF13);
    chk("R2 no take while level set", {31'b0, take_exc}, 32'h0);
    st_wr = 1; st_wdata = 32'h0000_0000;
    @(negedge clk);
    st_wr = 0;
    chk("R2 cleared", status_q, 32'h0);

    // R6/R7/R8: all request combinations
    for (int c = 1; c < 128; c++) begin
      logic [31:0] pc;
      logic dly;
      pc = 32'h0040_0000 + 32'(c) * 32'd16;
      dly = c[0] ^ c[3];
      set_req(7'(c)); fault_pc = pc; in_delay = dly;
      @(negedge clk);
      set_req('0); in_delay = 0;
      chk("R7 take pulse", {31'b0, take_exc}, 32'h1);
      chk("R6 code", {27'b0, cause_q[6:2]}, {27'b0, exp_code(7'(c))});
      chk("R8 delay flag", {31'b0, cause_q[31]}, {31'b0, dly});
      chk("R8 epc", epc_q, dly ? pc - 32'd4 : pc);
      chk("R7 level set", {31'b0, status_q[1]}, 32'h1);
      eret = 1;
      @(negedge clk);
      eret = 0;
      chk("R7 pulse width", {31'b0, take_exc}, 32'h0);
      chk("R9 eret clears", {31'b0, status_q[1]}, 32'h0);
    end

    // R9: trap and eret together
    req_sys = 1; eret = 1; fault_pc = 32'h100;
    @(negedge clk);
    req_sys = 0; eret = 0;
    chk("R9 trap beats eret", {31'b0, status_q[1]}, 32'h1);
    chk("R3 syscall code", {27'b0, cause_q[6:2]}, 32'd8);
    eret = 1;
    @(negedge clk);
    eret = 0;
    chk("R9 eret alone", {31'b0, status_q[1]}, 32'h0);

    // R4/R5: interrupt sweep
    for (int mi = 0; mi < 3; mi++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int v = 0; v < 64; v++) begin
          logic [7:0] m, pend;
          logic ie, exl, exp_take;
          m = (mi == 0) ? 8'hFC : (mi == 1) ? 8'h14 : 8'h03;
          ie = mode[0]; exl = mode[1];
          pend = 8'(v) << 2;
          exp_take = ((pend & m) != 0) && ie && !exl;
          st_wr = 1; st_wdata = {16'b0, m, 6'b0, exl, ie};
          @(negedge clk);
          st_wr = 0; irq = 6'(v);
          @(negedge clk);
          chk("R5 latency", {31'b0, take_exc}, 32'h0);
          @(negedge clk);
          chk("R4 pending", {24'b0, cause_q[15:8]}, {24'b0, pend});
          chk("R5 take", {31'b0, take_exc}, {31'b0, exp_take});
          if (exp_take) begin
            chk("R3 int code", {27'b0, cause_q[6:2]}, 32'h0);
            chk("R7 int level", {31'b0, status_q[1]}, 32'h1);
          end
          irq = '0; st_wr = 1; st_wdata = '0;
          @(negedge clk);
          st_wr = 0;
          @(negedge clk);
          chk("R4 write cannot touch pending", {24'b0, cause_q[15:8]}, 32'h0);
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule